// File: doc/BRIEF.md
# Masked Configuration Space with Base-Window Decode

This block holds the 256-byte configuration header of one bus function as 64 words of 32 bits. A constant write-enable mask, fixed by parameters, covers every word. Software reaches the header through a byte-addressed port that takes 8-, 16- and 32-bit accesses. A write changes only the bits that its word's mask permits. Reads return the addressed bytes, right-aligned and zero-extended, one cycle after the request.

Seven base-window registers are decoded into address windows: six general windows at word offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24, and an expansion-ROM window at 0x30. For each window the decode gives a kind (I/O or memory), a size, a base aligned to that size, and a valid flag. The mask sets both which address bits software may write and the window size. Only a full-word write whose masked value is neither zero nor the whole mask triggers a new decode, so a sizing probe of all ones leaves the current window in place.

A second port carries accesses aimed at the windows. These accesses are forwarded to the downstream target only when the matching enable bit in the command word allows them. A read that is held back returns zero, and a write that is held back is dropped. A synchronous reset reloads every word from its default and decodes the windows again from those defaults.

Top module: `cfg_space_bar`

## Requirements
- R1: A write updates each stored bit as (old AND NOT mask) OR (data AND mask), limited to the addressed byte lanes. Byte writes cover one lane, half-word writes two lanes at byte offset 0 or 2, and word writes all four lanes. Write data is right-aligned on cfg_wdata. In the command word at byte address 0x04, only bits 1:0 are writable.
- R2: A read with cfg_size 0 (byte), 1 (half-word) or 2 (word) raises cfg_rvalid one cycle after the request. cfg_rdata then carries the addressed bytes shifted down to bit 0 and zero-extended.
- R3: An access with cfg_size 3, a half-word at an odd address, or a word at an address that is not a multiple of 4 raises cfg_err one cycle later and changes no stored bit. If that access is a read, it also raises cfg_rvalid with cfg_rdata equal to zero.
- R4: A window is decoded again only on a word write to its offset whose masked data is neither zero nor equal to the mask. A write of all ones, or of zero, leaves the window outputs unchanged while the stored word still takes the masked value.
- R5: For a general window whose stored bit 0 is 1, the kind is I/O. Its size is the two's complement of the mask restricted to bits 31:2, with a minimum of 4. Its base is the stored word with bits 1:0 cleared and then aligned down to the size.
- R6: For a general window whose stored bit 0 is 0, the kind is memory. Its size is the two's complement of the mask restricted to bits 31:4, with a minimum of 16. Its base is the stored word with bits 3:0 cleared and then aligned down to the size.
- R7: For the ROM window (window index 6), bit 0 is an enable and bits 31:11 hold the address. Its size has a minimum of 2048. It is always of memory kind. A qualifying write with the enable clear makes the window invalid.
- R8: An access on the window port with acc_bar 0 to 6 is forwarded only if command bit 0 is set (I/O window) or command bit 1 is set (memory window). acc_bar 7 is never forwarded. A held-back read returns acc_rdata of zero, and a held-back write produces no tgt_valid pulse. acc_rvalid follows a read request by two cycles.
- R9: Reset reloads every word from its default. Each window is decoded from its default value when that value qualifies under R4, and is otherwise invalid.
- R10: A byte or half-word write that lands in a window word never re-decodes that window, even though the stored bits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration access request, one cycle per access |
| cfg_we | input | 1 | 1 for write, 0 for read |
| cfg_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| cfg_addr | input | 8 | Byte address in the header |
| cfg_wdata | input | 32 | Right-aligned write data |
| cfg_rvalid | output | 1 | Read response valid |
| cfg_rdata | output | 32 | Zero-extended read data |
| cfg_err | output | 1 | Misaligned or invalid-size access |
| win_valid | output | 7 | Window decoded and enabled, one bit per window |
| win_io | output | 7 | Window is of I/O kind |
| win_base | output | 224 | Window bases, window i at bits 32*i+31:32*i |
| win_size | output | 224 | Window sizes in bytes, same packing |
| acc_req | input | 1 | Window access request |
| acc_we | input | 1 | 1 for write, 0 for read |
| acc_bar | input | 3 | Window index 0 to 6 |
| acc_wdata | input | 32 | Window write data |
| acc_rvalid | output | 1 | Window read response valid |
| acc_rdata | output | 32 | Window read data, zero when held back |
| tgt_valid | output | 1 | Forwarded access to the downstream target |
| tgt_we | output | 1 | Forwarded access is a write |
| tgt_bar | output | 3 | Forwarded window index |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Target read data, valid in the cycle tgt_valid is high |

## Verification
The assertions assume that cfg_size and cfg_addr are stable for the single cycle in which cfg_req is high, and that tgt_rdata is a combinational answer to tgt_bar in the cycle after forwarding. The held-back-read assertion also relies on each window access being a single-cycle pulse. The stimulus issues each request for exactly one cycle and leaves at least one idle cycle between requests. Its target model is a pure function of tgt_bar. It drives acc_bar 7 only to test the always-blocked slot, and it reaches misaligned sizes only through accesses that are meant to raise cfg_err.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int NWIN   = 7;
  localparam int WORD_W = 32;
  localparam int ROM_IX = NWIN - 1;

  localparam logic [31:0] IO_ADDR_M  = 32'hFFFF_FFFC;
  localparam logic [31:0] MEM_ADDR_M = 32'hFFFF_FFF0;
  localparam logic [31:0] ROM_ADDR_M = 32'hFFFF_F800;
  localparam logic [31:0] IO_MIN     = 32'd4;
  localparam logic [31:0] MEM_MIN    = 32'd16;
  localparam logic [31:0] ROM_MIN    = 32'h0000_0800;

  typedef struct packed {
    logic        valid;
    logic        io;
    logic [31:0] base;
    logic [31:0] size;
  } win_t;

  // Window slot owning a header word; 7 means none.
  function automatic logic [2:0] slot_of(int idx);
    if (idx >= 4 && idx <= 9) return 3'(idx - 4);
    else if (idx == 12)       return 3'(ROM_IX);
    else                      return 3'd7;
  endfunction

  function automatic logic qualifies(logic [31:0] d, logic [31:0] m);
    return ((d & m) != 32'd0) && ((d & m) != m);
  endfunction

  function automatic win_t decode(logic rom, logic [31:0] d, logic [31:0] m);
    win_t        w;
    logic [31:0] am;
    logic [31:0] mn;
    logic [31:0] len;
    w = '0;
    if (rom) begin
      if (!d[0]) return w;
      am = ROM_ADDR_M; mn = ROM_MIN;
    end else if (d[0]) begin
      am = IO_ADDR_M;  mn = IO_MIN; w.io = 1'b1;
    end else begin
      am = MEM_ADDR_M; mn = MEM_MIN;
    end
    len = ~(m & am) + 32'd1;
    if (len < mn) len = mn;
    w.valid = 1'b1;
    w.size  = len;
    w.base  = (d & am) & ~(len - 32'd1);
    return w;
  endfunction

  // Default word: window words come from the packed window vector.
  function automatic logic [31:0] dflt_word(int idx, logic [31:0] w0, logic [31:0] w1,
                                            logic [31:0] w15, logic [NWIN*32-1:0] wins);
    logic [2:0] s;
    s = slot_of(idx);
    if (s != 3'd7) return wins[32*s +: 32];
    case (idx)
      0:       return w0;
      1:       return w1;
      15:      return w15;
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfgsp_store.sv
module cfgsp_store import cfgsp_pkg::*; #(
  parameter int                 ADDR_W    = 8,
  parameter logic [31:0]        ID_WORD   = 32'h0,
  parameter logic [31:0]        CMD_MASK  = 32'h3,
  parameter logic [31:0]        IRQ_RESET = 32'h0,
  parameter logic [31:0]        IRQ_MASK  = 32'h0,
  parameter logic [NWIN*32-1:0] BAR_RESET = '0,
  parameter logic [NWIN*32-1:0] BAR_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              err,
  output logic [1:0]        cmd_bits,
  output logic              wr_fire,
  output logic              wr_full,
  output logic [2:0]        wr_slot,
  output logic [31:0]       wr_new
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int WORDS  = 1 << WIDX_W;

  logic [31:0]       mem_q [WORDS];
  logic [WIDX_W-1:0] widx;
  logic [1:0]        off;
  logic              misal;
  logic [31:0]       lane, smask, old_w, m_w, eff_m;

  assign widx  = addr[ADDR_W-1:2];
  assign off   = addr[1:0];
  assign misal = (size == 2'd3) || (size == 2'd1 && off[0]) || (size == 2'd2 && off != 2'd0);

  always_comb begin
    case (size)
      2'd0:    smask = 32'h0000_00FF;
      2'd1:    smask = 32'h0000_FFFF;
      default: smask = 32'hFFFF_FFFF;
    endcase
  end

  assign lane    = smask << {off, 3'b000};
  assign old_w   = mem_q[widx];
  assign m_w     = dflt_word(int'(widx), 32'd0, CMD_MASK, IRQ_MASK, BAR_MASK);
  assign eff_m   = m_w & lane;
  assign wr_new  = (old_w & ~eff_m) | ((wdata << {off, 3'b000}) & eff_m);
  assign wr_fire = req && we && !misal;
  assign wr_full = (size == 2'd2);
  assign wr_slot = slot_of(int'(widx));
  assign cmd_bits = mem_q[1][1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++)
        mem_q[i] <= dflt_word(i, ID_WORD, 32'd0, IRQ_RESET, BAR_RESET);
    end else if (wr_fire) begin
      mem_q[widx] <= wr_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req && !we;
      err    <= req && misal;
      rdata  <= (req && !we && !misal) ? ((old_w >> {off, 3'b000}) & smask) : 32'd0;
    end
  end

  AST_RO_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (((mem_q[$past(widx)] ^ $past(old_w)) & ~$past(m_w)) == 32'd0)); // R1
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (err && rvalid) |-> (rdata == 32'd0)); // R3
endmodule

// File: rtl/cfgsp_bar_dec.sv
module cfgsp_bar_dec import cfgsp_pkg::*; #(
  parameter logic [NWIN*32-1:0] BAR_RESET = '0,
  parameter logic [NWIN*32-1:0] BAR_MASK  = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_fire,
  input  logic               wr_full,
  input  logic [2:0]         wr_slot,
  input  logic [31:0]        wr_data,
  input  logic [31:0]        wr_new,
  output logic [NWIN-1:0]    win_valid,
  output logic [NWIN-1:0]    win_io,
  output logic [NWIN*32-1:0] win_base,
  output logic [NWIN*32-1:0] win_size
);
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [31:0] M   = BAR_MASK[g*32 +: 32];
    localparam logic [31:0] R   = BAR_RESET[g*32 +: 32];
    localparam logic        ROM = (g == ROM_IX);
    win_t w_q;
    logic hit;

    assign hit = wr_fire && (wr_slot == 3'(g));

    always_ff @(posedge clk) begin
      if (rst)
        w_q <= qualifies(R, M) ? decode(ROM, R, M) : '0;
      else if (hit && wr_full && qualifies(wr_data, M))
        w_q <= decode(ROM, wr_new, M);
    end

    assign win_valid[g]         = w_q.valid;
    assign win_io[g]            = w_q.io;
    assign win_base[g*32 +: 32] = w_q.base;
    assign win_size[g*32 +: 32] = w_q.size;

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      w_q.valid |-> ((w_q.base & (w_q.size - 32'd1)) == 32'd0)); // R6
    AST_MIN_SIZE: assert property (@(posedge clk) disable iff (rst)
      w_q.valid |-> (w_q.size >= (w_q.io ? IO_MIN : (ROM ? ROM_MIN : MEM_MIN)))); // R5
    AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (hit && wr_full && ((wr_data & M) == M)) |=> $stable(w_q)); // R4
    AST_SUBWORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (hit && !wr_full) |=> $stable(w_q)); // R10
    if (g == ROM_IX) begin : g_rom
      AST_ROM_IS_MEM: assert property (@(posedge clk) disable iff (rst)
        w_q.valid |-> !w_q.io); // R7
    end
  end
endmodule

// File: rtl/cfgsp_gate.sv
module cfgsp_gate import cfgsp_pkg::*; #(
  parameter int BW = 3,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_req,
  input  logic            acc_we,
  input  logic [BW-1:0]   acc_bar,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [1:0]      cmd_bits,
  input  logic [NWIN-1:0] win_io,
  output logic            tgt_valid,
  output logic            tgt_we,
  output logic [BW-1:0]   tgt_bar,
  output logic [DW-1:0]   tgt_wdata,
  input  logic [DW-1:0]   tgt_rdata,
  output logic            acc_rvalid,
  output logic [DW-1:0]   acc_rdata
);
  localparam int NSLOT = 1 << BW;

  logic [NSLOT-1:0] io_pad;
  logic             in_range, is_io, allow;
  logic             rd_pend, rd_ok, io_q;

  assign io_pad   = {{(NSLOT-NWIN){1'b0}}, win_io};
  assign in_range = (int'(acc_bar) < NWIN);
  assign is_io    = in_range && io_pad[acc_bar];
  assign allow    = in_range && (is_io ? cmd_bits[0] : cmd_bits[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid  <= 1'b0;
      tgt_we     <= 1'b0;
      tgt_bar    <= '0;
      tgt_wdata  <= '0;
      rd_pend    <= 1'b0;
      rd_ok      <= 1'b0;
      io_q       <= 1'b0;
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      tgt_valid  <= acc_req && allow;
      tgt_we     <= acc_we;
      tgt_bar    <= acc_bar;
      tgt_wdata  <= acc_wdata;
      rd_pend    <= acc_req && !acc_we;
      rd_ok      <= allow;
      io_q       <= is_io;
      acc_rvalid <= rd_pend;
      acc_rdata  <= (rd_pend && rd_ok) ? tgt_rdata : '0;
    end
  end

  AST_IO_GATE: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && io_q) |-> $past(cmd_bits[0])); // R8
  AST_MEM_GATE: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && !io_q) |-> $past(cmd_bits[1])); // R8
  AST_BLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && !rd_ok) |=> (acc_rvalid && acc_rdata == '0)); // R8
endmodule

// File: rtl/cfg_space_bar.sv
module cfg_space_bar import cfgsp_pkg::*; #(
  parameter int                 ADDR_W    = 8,
  parameter int                 BW        = 3,
  parameter logic [31:0]        ID_WORD   = 32'hBEEF_1AB0,
  parameter logic [31:0]        CMD_MASK  = 32'h0000_0003,
  parameter logic [31:0]        IRQ_RESET = 32'h0000_01FF,
  parameter logic [31:0]        IRQ_MASK  = 32'h0000_00FF,
  parameter logic [NWIN*32-1:0] BAR_MASK  = {32'hFFFF_0001, 32'h0000_0000, 32'hFFFF_FFF0,
                                             32'hFFFF_FFFC, 32'hFFF0_0000, 32'hFFFF_F000,
                                             32'hFFFF_FF00},
  parameter logic [NWIN*32-1:0] BAR_RESET = {32'h0, 32'h0, 32'h0, 32'h0000_0001,
                                             32'h0, 32'h8000_0000, 32'h0000_0001}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_req,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_size,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               cfg_rvalid,
  output logic [31:0]        cfg_rdata,
  output logic               cfg_err,
  output logic [NWIN-1:0]    win_valid,
  output logic [NWIN-1:0]    win_io,
  output logic [NWIN*32-1:0] win_base,
  output logic [NWIN*32-1:0] win_size,
  input  logic               acc_req,
  input  logic               acc_we,
  input  logic [BW-1:0]      acc_bar,
  input  logic [31:0]        acc_wdata,
  output logic               acc_rvalid,
  output logic [31:0]        acc_rdata,
  output logic               tgt_valid,
  output logic               tgt_we,
  output logic [BW-1:0]      tgt_bar,
  output logic [31:0]        tgt_wdata,
  input  logic [31:0]        tgt_rdata
);
  logic [1:0]  cmd_bits;
  logic        wr_fire, wr_full;
  logic [2:0]  wr_slot;
  logic [31:0] wr_new;

  cfgsp_store #(
    .ADDR_W(ADDR_W), .ID_WORD(ID_WORD), .CMD_MASK(CMD_MASK), .IRQ_RESET(IRQ_RESET),
    .IRQ_MASK(IRQ_MASK), .BAR_RESET(BAR_RESET), .BAR_MASK(BAR_MASK)
  ) u_store (
    .clk(clk), .rst(rst), .req(cfg_req), .we(cfg_we), .size(cfg_size), .addr(cfg_addr),
    .wdata(cfg_wdata), .rvalid(cfg_rvalid), .rdata(cfg_rdata), .err(cfg_err),
    .cmd_bits(cmd_bits), .wr_fire(wr_fire), .wr_full(wr_full), .wr_slot(wr_slot),
    .wr_new(wr_new)
  );

  cfgsp_bar_dec #(.BAR_RESET(BAR_RESET), .BAR_MASK(BAR_MASK)) u_dec (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_full(wr_full), .wr_slot(wr_slot),
    .wr_data(cfg_wdata), .wr_new(wr_new), .win_valid(win_valid), .win_io(win_io),
    .win_base(win_base), .win_size(win_size)
  );

  cfgsp_gate #(.BW(BW), .DW(32)) u_gate (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we), .acc_bar(acc_bar),
    .acc_wdata(acc_wdata), .cmd_bits(cmd_bits), .win_io(win_io), .tgt_valid(tgt_valid),
    .tgt_we(tgt_we), .tgt_bar(tgt_bar), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
    .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata)
  );
endmodule

// File: tb/sim_cfg_space_bar.sv
`timescale 1ns/1ps
module sim_cfg_space_bar;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_req = 1'b0, cfg_we = 1'b0;
  logic [1:0]   cfg_size = 2'd0;
  logic [7:0]   cfg_addr = 8'd0;
  logic [31:0]  cfg_wdata = 32'd0;
  logic         cfg_rvalid, cfg_err;
  logic [31:0]  cfg_rdata;
  logic [6:0]   win_valid, win_io;
  logic [223:0] win_base, win_size;
  logic         acc_req = 1'b0, acc_we = 1'b0;
  logic [2:0]   acc_bar = 3'd0;
  logic [31:0]  acc_wdata = 32'd0;
  logic         acc_rvalid, tgt_valid, tgt_we;
  logic [31:0]  acc_rdata, tgt_wdata, tgt_rdata;
  logic [2:0]   tgt_bar;

  always #4 clk = ~clk;

  // Target model: answers with a tag of the forwarded window index.
  assign tgt_rdata = 32'hA5A5_0000 | {29'd0, tgt_bar};

  cfg_space_bar u0 (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err), .win_valid(win_valid), .win_io(win_io), .win_base(win_base),
    .win_size(win_size), .acc_req(acc_req), .acc_we(acc_we), .acc_bar(acc_bar),
    .acc_wdata(acc_wdata), .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
    .tgt_valid(tgt_valid), .tgt_we(tgt_we), .tgt_bar(tgt_bar), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata)
  );

  typedef struct { logic rv; logic er; logic [31:0] d; int req; } exp_t;
  exp_t cq[$];
  exp_t aq[$];
  int n_run = 0, n_fail = 0, fwd_cnt = 0;
  logic [2:0]  last_bar = 3'd0;
  logic [31:0] last_wd = 32'd0;

  task automatic chk(input bit ok, input int r, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected responses as the design returns them.
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (cfg_rvalid || cfg_err) begin
        if (cq.size() == 0) chk(1'b0, 3, {31'd0, cfg_rvalid, cfg_rdata}, 64'd0, "unexpected cfg response");
        else begin
          e = cq.pop_front();
          chk(cfg_rvalid == e.rv && cfg_err == e.er && cfg_rdata == e.d, e.req,
              {30'd0, cfg_rvalid, cfg_err, cfg_rdata}, {30'd0, e.rv, e.er, e.d}, "cfg response");
        end
      end
      if (acc_rvalid) begin
        if (aq.size() == 0) chk(1'b0, 8, {32'd0, acc_rdata}, 64'd0, "unexpected window response");
        else begin
          e = aq.pop_front();
          chk(acc_rdata == e.d, e.req, {32'd0, acc_rdata}, {32'd0, e.d}, "window read data");
        end
      end
      if (tgt_valid && tgt_we) begin
        fwd_cnt++;
        last_bar = tgt_bar;
        last_wd  = tgt_wdata;
      end
    end
  end

  task automatic cfg_op(input logic we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, input logic erx, input logic [31:0] dx, input int r);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_size = sz; cfg_addr = a; cfg_wdata = wd;
    if (!we || erx) cq.push_back('{rv: !we, er: erx, d: dx, req: r});
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic acc_op(input logic we, input logic [2:0] b, input logic [31:0] wd,
                        input logic [31:0] dx, input int r);
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_bar = b; acc_wdata = wd;
    if (!we) aq.push_back('{rv: 1'b1, er: 1'b0, d: dx, req: r});
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_win(input int i, input logic v, input logic io, input logic [31:0] b,
                         input logic [31:0] s, input int r);
    chk(win_valid[i] == v, r, {63'd0, win_valid[i]}, {63'd0, v}, $sformatf("window %0d valid", i));
    if (v) begin
      chk(win_io[i] == io, r, {63'd0, win_io[i]}, {63'd0, io}, $sformatf("window %0d kind", i));
      chk(win_base[i*32 +: 32] == b, r, {32'd0, win_base[i*32 +: 32]}, {32'd0, b},
          $sformatf("window %0d base", i));
      chk(win_size[i*32 +: 32] == s, r, {32'd0, win_size[i*32 +: 32]}, {32'd0, s},
          $sformatf("window %0d size", i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, 0, 64'd0, 64'd1, "watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset decode of the defaults
    chk_win(1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_1000, 9);
    chk_win(0, 1'b0, 1'b0, 32'd0, 32'd0, 9);
    chk_win(6, 1'b0, 1'b0, 32'd0, 32'd0, 9);
    // R2: reads of several widths
    cfg_op(1'b0, 2'd2, 8'h00, 32'd0, 1'b0, 32'hBEEF_1AB0, 2);
    cfg_op(1'b0, 2'd0, 8'h01, 32'd0, 1'b0, 32'h0000_001A, 2);
    cfg_op(1'b0, 2'd1, 8'h02, 32'd0, 1'b0, 32'h0000_BEEF, 2);
    cfg_op(1'b0, 2'd0, 8'h3C, 32'd0, 1'b0, 32'h0000_00FF, 2);
    // R3: misaligned and invalid size
    cfg_op(1'b0, 2'd1, 8'h01, 32'd0, 1'b1, 32'd0, 3);
    cfg_op(1'b0, 2'd3, 8'h00, 32'd0, 1'b1, 32'd0, 3);
    cfg_op(1'b1, 2'd2, 8'h12, 32'hFFFF_0000, 1'b1, 32'd0, 3);
    cfg_op(1'b0, 2'd2, 8'h10, 32'd0, 1'b0, 32'h0000_0001, 3);
    // R8: all windows held back while the command word is zero
    acc_op(1'b0, 3'd1, 32'd0, 32'd0, 8);
    acc_op(1'b1, 3'd1, 32'h77, 32'd0, 8);
    drain();
    chk(fwd_cnt == 0, 8, 64'(fwd_cnt), 64'd0, "held-back write forwarded");
    // R1: command byte write keeps only writable bits
    cfg_op(1'b1, 2'd0, 8'h04, 32'h0000_00FF, 1'b0, 32'd0, 1);
    cfg_op(1'b0, 2'd2, 8'h04, 32'd0, 1'b0, 32'h0000_0003, 1);
    // R5: I/O window decode
    cfg_op(1'b1, 2'd2, 8'h10, 32'h0000_1234, 1'b0, 32'd0, 5);
    chk_win(0, 1'b1, 1'b1, 32'h0000_1200, 32'h0000_0100, 5);
    cfg_op(1'b0, 2'd2, 8'h10, 32'd0, 1'b0, 32'h0000_1201, 1);
    // R4: all-ones probe and zero write do not re-decode
    cfg_op(1'b1, 2'd2, 8'h10, 32'hFFFF_FFFF, 1'b0, 32'd0, 4);
    chk_win(0, 1'b1, 1'b1, 32'h0000_1200, 32'h0000_0100, 4);
    cfg_op(1'b0, 2'd2, 8'h10, 32'd0, 1'b0, 32'hFFFF_FF01, 4);
    cfg_op(1'b1, 2'd2, 8'h10, 32'h0000_0000, 1'b0, 32'd0, 4);
    chk_win(0, 1'b1, 1'b1, 32'h0000_1200, 32'h0000_0100, 4);
    // R5: smallest I/O window
    cfg_op(1'b1, 2'd2, 8'h1C, 32'h0000_0C08, 1'b0, 32'd0, 5);
    chk_win(3, 1'b1, 1'b1, 32'h0000_0C08, 32'd4, 5);
    // R6: memory windows, smallest and large
    cfg_op(1'b1, 2'd2, 8'h20, 32'h0000_5430, 1'b0, 32'd0, 6);
    chk_win(4, 1'b1, 1'b0, 32'h0000_5430, 32'd16, 6);
    cfg_op(1'b1, 2'd2, 8'h18, 32'h1234_5678, 1'b0, 32'd0, 6);
    chk_win(2, 1'b1, 1'b0, 32'h1230_0000, 32'h0010_0000, 6);
    // R10: half-word write in a window word
    cfg_op(1'b1, 2'd1, 8'h1A, 32'h0000_ABCD, 1'b0, 32'd0, 10);
    cfg_op(1'b0, 2'd2, 8'h18, 32'd0, 1'b0, 32'hABC0_0000, 1);
    chk_win(2, 1'b1, 1'b0, 32'h1230_0000, 32'h0010_0000, 10);
    // R7: ROM window enable
    cfg_op(1'b1, 2'd2, 8'h30, 32'h000A_0000, 1'b0, 32'd0, 7);
    chk_win(6, 1'b0, 1'b0, 32'd0, 32'd0, 7);
    cfg_op(1'b1, 2'd0, 8'h30, 32'h0000_0001, 1'b0, 32'd0, 10);
    chk_win(6, 1'b0, 1'b0, 32'd0, 32'd0, 10);
    cfg_op(1'b0, 2'd2, 8'h30, 32'd0, 1'b0, 32'h000A_0001, 10);
    cfg_op(1'b1, 2'd2, 8'h30, 32'h000A_0001, 1'b0, 32'd0, 7);
    chk_win(6, 1'b1, 1'b0, 32'h000A_0000, 32'h0001_0000, 7);
    // R8: both enables set
    acc_op(1'b0, 3'd1, 32'd0, 32'hA5A5_0001, 8);
    acc_op(1'b1, 3'd0, 32'h0000_CAFE, 32'd0, 8);
    drain();
    chk(fwd_cnt == 1, 8, 64'(fwd_cnt), 64'd1, "I/O write count");
    chk(last_bar == 3'd0 && last_wd == 32'h0000_CAFE, 8, {29'd0, last_bar, last_wd},
        {29'd0, 3'd0, 32'h0000_CAFE}, "forwarded write");
    // R8: memory enable only
    cfg_op(1'b1, 2'd0, 8'h04, 32'h0000_0002, 1'b0, 32'd0, 8);
    acc_op(1'b1, 3'd0, 32'h0000_1111, 32'd0, 8);
    acc_op(1'b0, 3'd0, 32'd0, 32'd0, 8);
    acc_op(1'b0, 3'd4, 32'd0, 32'hA5A5_0004, 8);
    acc_op(1'b0, 3'd7, 32'd0, 32'd0, 8);
    drain();
    chk(fwd_cnt == 1, 8, 64'(fwd_cnt), 64'd1, "I/O write with I/O disabled");
    // R9: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_win(0, 1'b0, 1'b0, 32'd0, 32'd0, 9);
    chk_win(1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_1000, 9);
    chk_win(6, 1'b0, 1'b0, 32'd0, 32'd0, 9);
    cfg_op(1'b0, 2'd2, 8'h10, 32'd0, 1'b0, 32'h0000_0001, 9);
    cfg_op(1'b0, 2'd2, 8'h04, 32'd0, 1'b0, 32'h0000_0000, 9);
    drain();
    chk(cq.size() == 0 && aq.size() == 0, 2, 64'(cq.size() + aq.size()), 64'd0,
        "responses outstanding");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule